// File: doc/BRIEF.md
# Standby Power Mode Controller

This block is a small state machine that moves a microcontroller into a deep standby state and brings it back out. It enters standby when the CPU issues a sleep strobe while a standby-select bit is set. It then stops the CPU clock and the oscillator, and holds the peripheral blocks in reset. On entry it also clears the refresh counter state, through a one-cycle strobe.

There are three ways out of standby, and each takes its own path.

- **Interrupt wake.** An NMI, or an enabled and unmasked IRQ, restarts the oscillator first. The clocks return only after a settling count picked by a 3-bit code, and then interrupt exception handling is started.
- **Reset wake.** A low reset pin brings the clocks back at once and waits for the pin to be released.
- **Hardware standby.** A low hardware-standby pin overrides everything else.

All timing runs on a free-running reference clock `clk`. The synchronous reset `rst` is active high and puts the block in the running state.

Top module: `stby_ctl`

## Requirements
- R1: After `rst`, the controller is in the running state: `clk_en_o`=1, `osc_en_o`=1, and `periph_rst_o`, `rfsh_clr_o`, `int_start_o`, `rst_start_o` and `hw_stby_o` are all 0.
- R2: When `sleep_i`=1 and `ssel_i`=1 at a clock edge while running, the next cycle shows standby: `clk_en_o`=0, `osc_en_o`=0 and `periph_rst_o`=1. A sleep strobe with `ssel_i`=0 changes no output.
- R3: `rfsh_clr_o` is a one-cycle pulse. It appears in the first standby cycle, and only on entry to software standby.
- R4: An NMI in standby raises `osc_en_o` in the next cycle, while `clk_en_o` stays 0 and `periph_rst_o` stays 1 during settling.
- R5: The settling length N in reference cycles is (2^E) >> `CNT_SHIFT`, where E is 13, 14, 15, 16, 17, 10, 11 or 12 for `sts_i` codes 0 to 7. `int_start_o` and `clk_en_o`=1 appear exactly N cycles after `osc_en_o` rises, and `periph_rst_o` falls in that same cycle.
- R6: IRQ line k wakes the controller only when `irq_en_i[k]`=1 and `cpu_mask_i`=0. Otherwise the controller stays in standby with `osc_en_o`=0. NMI ignores both the enable bits and the mask.
- R7: `int_src_o` gives the waking source while `int_start_o`=1: 0 for NMI, 1 for IRQ0, 2 for IRQ1, 3 for IRQ2. When several sources request at once, the priority is NMI, then IRQ0, then IRQ1, then IRQ2.
- R8: With `resn_i`=0 in standby or during settling, the next cycle has `clk_en_o`=1, `osc_en_o`=1 and `periph_rst_o`=1, with no settling count. Reset takes precedence over a simultaneous interrupt and aborts a running count, so no `int_start_o` follows.
- R9: In the reset wait, `resn_i`=1 gives a single `rst_start_o` pulse in the next cycle, with `periph_rst_o`=0.
- R10: `hstbyn_i`=0 gives `hw_stby_o`=1, `clk_en_o`=0 and `osc_en_o`=0 in the next cycle from any state, ahead of every other input. Once `hstbyn_i` returns to 1, the controller passes through the reset wait.
- R11: `int_start_o` and `rst_start_o` are single-cycle pulses.
- R12: The settling code is captured when the wake is accepted. Changing `sts_i` during settling does not change N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Sleep instruction strobe |
| ssel_i | input | 1 | Standby-select control bit |
| sts_i | input | 3 | Settling-time select code |
| nmi_i | input | 1 | Non-maskable interrupt request |
| irq_i | input | N_IRQ | IRQ request lines |
| irq_en_i | input | N_IRQ | IRQ enable bits |
| cpu_mask_i | input | 1 | CPU interrupt mask (1 masks the IRQs) |
| resn_i | input | 1 | Reset pin, active low |
| hstbyn_i | input | 1 | Hardware-standby pin, active low |
| clk_en_o | output | 1 | CPU and system clock gate enable |
| osc_en_o | output | 1 | Oscillator enable |
| periph_rst_o | output | 1 | Peripheral and DMA reset |
| rfsh_clr_o | output | 1 | Refresh counter clear strobe |
| int_start_o | output | 1 | Start interrupt exception handling |
| int_src_o | output | SRC_W | Waking interrupt source code |
| rst_start_o | output | 1 | Start reset exception handling |
| hw_stby_o | output | 1 | Hardware standby active |

## Verification
Some functions can fall in the same cycle, and each such collision is provoked and judged.

**Reset against settling.** The bench pulls `resn_i` low in the very cycle the settling count would expire. It expects the reset path's clocks, and it expects no `int_start_o` at any point afterwards.

**Reset against NMI.** The bench raises `resn_i`=0 together with `nmi_i`. Reset must win.

**Hardware standby against sleep.** The bench drives `hstbyn_i` low in the same cycle as a qualifying sleep strobe. It then checks that `hw_stby_o` rises and that no refresh-clear pulse appears.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_STBY   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_RSTW   = 3'd3,
    ST_HWSTBY = 3'd4
  } stby_state_e;

  localparam int MAX_EXP = 17;
  localparam int CNT_W   = MAX_EXP + 1;

  // exponent of the settling count for each select code
  function automatic int settle_exp(input logic [2:0] code);
    case (code)
      3'd0: settle_exp = 13;
      3'd1: settle_exp = 14;
      3'd2: settle_exp = 15;
      3'd3: settle_exp = 16;
      3'd4: settle_exp = 17;
      3'd5: settle_exp = 10;
      3'd6: settle_exp = 11;
      default: settle_exp = 12;
    endcase
  endfunction
endpackage

// File: rtl/stby_wake_sel.sv
module stby_wake_sel #(
  parameter int N_IRQ = 3,
  localparam int SRC_W = $clog2(N_IRQ + 1)
) (
  input  logic             nmi_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             cpu_mask_i,
  output logic             wake_o,
  output logic [SRC_W-1:0] src_o
);
  logic [N_IRQ-1:0] live;
  assign live = cpu_mask_i ? '0 : (irq_i & irq_en_i);

  always_comb begin
    wake_o = nmi_i | (|live);
    src_o  = '0;
    if (!nmi_i) begin
      // scan from the lowest-priority line so the lowest index wins
      for (int k = N_IRQ - 1; k >= 0; k--) begin
        if (live[k]) src_o = SRC_W'(k + 1);
      end
    end
  end
endmodule

// File: rtl/stby_settle.sv
module stby_settle
  import stby_pkg::*;
#(
  parameter int CNT_SHIFT = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic [2:0] sts_i,
  input  logic       run_i,
  output logic       done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;

  function automatic logic [CNT_W-1:0] len_of(input logic [2:0] code);
    logic [CNT_W-1:0] full;
    logic [CNT_W-1:0] sh;
    full = CNT_W'(1) << settle_exp(code);
    sh   = full >> CNT_SHIFT;
    len_of = (sh == '0) ? CNT_W'(1) : sh;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      len_q <= CNT_W'(1);
    end else if (load_i) begin
      cnt_q <= '0;
      len_q <= len_of(sts_i);
    end else if (run_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = run_i && (cnt_q == len_q - 1'b1);
endmodule

// File: rtl/stby_ctl.sv
module stby_ctl
  import stby_pkg::*;
#(
  parameter int CNT_SHIFT = 0,
  parameter int N_IRQ     = 3,
  localparam int SRC_W    = $clog2(N_IRQ + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_i,
  input  logic             ssel_i,
  input  logic [2:0]       sts_i,
  input  logic             nmi_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             cpu_mask_i,
  input  logic             resn_i,
  input  logic             hstbyn_i,
  output logic             clk_en_o,
  output logic             osc_en_o,
  output logic             periph_rst_o,
  output logic             rfsh_clr_o,
  output logic             int_start_o,
  output logic [SRC_W-1:0] int_src_o,
  output logic             rst_start_o,
  output logic             hw_stby_o
);
  stby_state_e state_q, nxt;
  logic             wake, done, load, go_int, go_rst, clr_r;
  logic [SRC_W-1:0] src;
  logic [SRC_W-1:0] src_q;

  stby_wake_sel #(.N_IRQ(N_IRQ)) u_wake (
    .nmi_i      (nmi_i),
    .irq_i      (irq_i),
    .irq_en_i   (irq_en_i),
    .cpu_mask_i (cpu_mask_i),
    .wake_o     (wake),
    .src_o      (src)
  );

  stby_settle #(.CNT_SHIFT(CNT_SHIFT)) u_settle (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .sts_i  (sts_i),
    .run_i  (state_q == ST_SETTLE),
    .done_o (done)
  );

  // next state; priority: standby pin, reset pin, NMI, IRQs
  always_comb begin
    nxt    = state_q;
    load   = 1'b0;
    go_int = 1'b0;
    go_rst = 1'b0;
    clr_r  = 1'b0;
    if (!hstbyn_i) begin
      nxt = ST_HWSTBY;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (sleep_i && ssel_i) begin
            nxt   = ST_STBY;
            clr_r = 1'b1;
          end
        end
        ST_STBY: begin
          if (!resn_i) begin
            nxt = ST_RSTW;
          end else if (wake) begin
            nxt  = ST_SETTLE;
            load = 1'b1;
          end
        end
        ST_SETTLE: begin
          if (!resn_i) begin
            nxt = ST_RSTW;
          end else if (done) begin
            nxt    = ST_RUN;
            go_int = 1'b1;
          end
        end
        ST_RSTW: begin
          if (resn_i) begin
            nxt    = ST_RUN;
            go_rst = 1'b1;
          end
        end
        default: nxt = ST_RSTW;
      endcase
    end
  end

  // state and registered outputs, decoded from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_RUN;
      clk_en_o     <= 1'b1;
      osc_en_o     <= 1'b1;
      periph_rst_o <= 1'b0;
      rfsh_clr_o   <= 1'b0;
      int_start_o  <= 1'b0;
      rst_start_o  <= 1'b0;
      hw_stby_o    <= 1'b0;
      src_q        <= '0;
    end else begin
      state_q      <= nxt;
      clk_en_o     <= (nxt == ST_RUN) || (nxt == ST_RSTW);
      osc_en_o     <= (nxt == ST_RUN) || (nxt == ST_RSTW) || (nxt == ST_SETTLE);
      periph_rst_o <= (nxt != ST_RUN);
      rfsh_clr_o   <= clr_r;
      int_start_o  <= go_int;
      rst_start_o  <= go_rst;
      hw_stby_o    <= (nxt == ST_HWSTBY);
      if (load) src_q <= src;
    end
  end

  assign int_src_o = src_q;
endmodule

// File: rtl/stby_ctl_chk.sv
module stby_ctl_chk (
  input logic clk,
  input logic rst,
  input logic resn_i,
  input logic hstbyn_i,
  input logic clk_en_o,
  input logic osc_en_o,
  input logic periph_rst_o,
  input logic rfsh_clr_o,
  input logic int_start_o,
  input logic rst_start_o,
  input logic hw_stby_o
);
  // R10
  hw_pin_wins_chk: assert property (@(posedge clk) disable iff (rst)
    !hstbyn_i |=> (hw_stby_o && !clk_en_o && !osc_en_o));

  // R11
  int_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    int_start_o |=> !int_start_o);

  // R11
  rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rst_start_o |=> !rst_start_o);

  // R3
  rfsh_entry_chk: assert property (@(posedge clk) disable iff (rst)
    rfsh_clr_o |-> (!clk_en_o && !osc_en_o && $past(clk_en_o)));

  // R8
  reset_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_o && !hw_stby_o && !resn_i && hstbyn_i) |=> (clk_en_o && osc_en_o && periph_rst_o));

  // R2
  gated_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_en_o |-> periph_rst_o);

  // R5
  int_clocks_chk: assert property (@(posedge clk) disable iff (rst)
    int_start_o |-> (clk_en_o && osc_en_o && !periph_rst_o));
endmodule

bind stby_ctl stby_ctl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .resn_i       (resn_i),
  .hstbyn_i     (hstbyn_i),
  .clk_en_o     (clk_en_o),
  .osc_en_o     (osc_en_o),
  .periph_rst_o (periph_rst_o),
  .rfsh_clr_o   (rfsh_clr_o),
  .int_start_o  (int_start_o),
  .rst_start_o  (rst_start_o),
  .hw_stby_o    (hw_stby_o)
);

// File: tb/sim_stby_ctl.sv
`timescale 1ns/1ps
module sim_stby_ctl;
  localparam int SH = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic sleep_i = 0, ssel_i = 0, nmi_i = 0, cpu_mask_i = 0, resn_i = 1, hstbyn_i = 1;
  logic [2:0] sts_i = 0, irq_i = 0, irq_en_i = 0;
  logic clk_en_o, osc_en_o, periph_rst_o, rfsh_clr_o, int_start_o, rst_start_o, hw_stby_o;
  logic [1:0] int_src_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stby_ctl #(.CNT_SHIFT(SH)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int exp_len(input logic [2:0] c);
    int e;
    case (c)
      3'd0: e = 13;
      3'd1: e = 14;
      3'd2: e = 15;
      3'd3: e = 16;
      3'd4: e = 17;
      3'd5: e = 10;
      3'd6: e = 11;
      default: e = 12;
    endcase
    exp_len = ((1 << e) >> SH) < 1 ? 1 : ((1 << e) >> SH);
  endfunction

  function automatic int exp_src(input bit n, input logic [2:0] q);
    if (n) return 0;
    for (int k = 0; k < 3; k++) if (q[k]) return k + 1;
    return 0;
  endfunction

  task automatic enter_stby();
    sleep_i = 1;
    ssel_i  = 1;
    step();
    sleep_i = 0;
    chk(!clk_en_o && !osc_en_o && periph_rst_o, "R2 standby entry", clk_en_o, 0);
    chk(rfsh_clr_o == 1, "R3 refresh clear pulse", rfsh_clr_o, 1);
    step();
    chk(rfsh_clr_o == 0, "R3 refresh clear single", rfsh_clr_o, 0);
  endtask

  // wake already requested on the inputs; count until int_start
  task automatic await_int(input int n_exp, input int s_exp, input string tag);
    int n = 0;
    step();
    nmi_i = 0;
    irq_i = 0;
    chk(osc_en_o && !clk_en_o && periph_rst_o, "R4 oscillator restarts first", osc_en_o, 1);
    while (n < 400) begin
      step();
      n++;
      if (int_start_o) break;
    end
    chk(n == n_exp, {"R5 settling length ", tag}, n, n_exp);
    chk(int_src_o == s_exp, "R7 source code", int_src_o, s_exp);
    chk(clk_en_o && !periph_rst_o, "R5 clocks back", clk_en_o, 1);
    step();
    chk(!int_start_o, "R11 interrupt start single", int_start_o, 0);
  endtask

  initial begin
    repeat (3) step();
    rst = 0;
    chk(clk_en_o && osc_en_o && !periph_rst_o && !rfsh_clr_o && !int_start_o
        && !rst_start_o && !hw_stby_o, "R1 reset state", clk_en_o, 1);

    // R2: sleep without standby select has no effect
    sleep_i = 1;
    ssel_i  = 0;
    step();
    sleep_i = 0;
    chk(clk_en_o && osc_en_o && !periph_rst_o && !rfsh_clr_o, "R2 no standby on ssel 0", clk_en_o, 1);

    // NMI wake, every settling code
    for (int c = 0; c < 8; c++) begin
      enter_stby();
      sts_i = 3'(c);
      nmi_i = 1;
      await_int(exp_len(3'(c)), 0, "per code");
    end

    // R6: a masked or disabled IRQ does not wake; NMI still does
    enter_stby();
    irq_i      = 3'b111;
    irq_en_i   = 3'b111;
    cpu_mask_i = 1;
    step();
    step();
    chk(!osc_en_o, "R6 masked IRQ ignored", osc_en_o, 0);
    cpu_mask_i = 0;
    irq_en_i   = 3'b000;
    step();
    step();
    chk(!osc_en_o, "R6 disabled IRQ ignored", osc_en_o, 0);
    irq_en_i   = 3'b110;
    cpu_mask_i = 1;
    nmi_i      = 1;
    sts_i      = 3'd5;
    await_int(exp_len(3'd5), 0, "nmi under mask");
    cpu_mask_i = 0;

    // R12: a change of the select during settling does not count
    enter_stby();
    sts_i    = 3'd7;
    irq_en_i = 3'b111;
    irq_i    = 3'b110;
    step();
    irq_i = 0;
    sts_i = 3'd4;
    begin
      int n = 0;
      while (n < 400) begin
        step();
        n++;
        if (int_start_o) break;
      end
      chk(n == exp_len(3'd7), "R12 select captured at wake", n, exp_len(3'd7));
      chk(int_src_o == 2, "R7 IRQ1 beats IRQ2", int_src_o, 2);
    end
    step();

    // R8: reset beats a simultaneous NMI
    enter_stby();
    nmi_i  = 1;
    resn_i = 0;
    step();
    nmi_i = 0;
    chk(clk_en_o && osc_en_o && periph_rst_o, "R8 reset beats NMI", clk_en_o, 1);
    step();
    chk(!rst_start_o && clk_en_o, "R8 waits for reset release", rst_start_o, 0);
    resn_i = 1;
    step();
    chk(rst_start_o && !periph_rst_o, "R9 reset start on release", rst_start_o, 1);
    step();
    chk(!rst_start_o, "R11 reset start single", rst_start_o, 0);

    // R8: reset in the cycle the count would expire
    enter_stby();
    sts_i = 3'd7;
    nmi_i = 1;
    step();
    nmi_i = 0;
    repeat (exp_len(3'd7) - 1) step();
    resn_i = 0;
    step();
    chk(!int_start_o && clk_en_o && periph_rst_o, "R8 reset aborts settling", int_start_o, 0);
    begin
      bit seen = 0;
      repeat (10) begin
        step();
        if (int_start_o) seen = 1;
      end
      chk(!seen, "R8 no interrupt start after abort", seen, 0);
    end
    resn_i = 1;
    step();
    step();

    // R10: hardware standby beats a qualifying sleep
    sleep_i  = 1;
    ssel_i   = 1;
    hstbyn_i = 0;
    step();
    sleep_i = 0;
    chk(hw_stby_o && !clk_en_o && !osc_en_o && !rfsh_clr_o, "R10 standby pin wins", hw_stby_o, 1);
    hstbyn_i = 1;
    step();
    chk(!hw_stby_o && clk_en_o && !rst_start_o, "R10 exit through reset wait", hw_stby_o, 0);
    step();
    chk(rst_start_o == 1, "R10 reset start after pin release", rst_start_o, 1);
    step();

    // random wakes
    void'($urandom(32'd1234));
    for (int it = 0; it < 30; it++) begin
      logic [2:0] q, en;
      bit n, m, w;
      q  = 3'($urandom);
      en = 3'($urandom);
      n  = ($urandom % 4) == 0;
      m  = $urandom % 2;
      w  = n || (((q & en) != 0) && !m);
      enter_stby();
      sts_i      = 3'($urandom);
      nmi_i      = n;
      irq_i      = q;
      irq_en_i   = en;
      cpu_mask_i = m;
      if (w) begin
        await_int(exp_len(sts_i), exp_src(n, m ? 3'b000 : (q & en)), "random");
      end else begin
        step();
        chk(!osc_en_o, "R6 random no wake", osc_en_o, 0);
        irq_i = 0;
        nmi_i = 1;
        await_int(exp_len(sts_i), 0, "random exit");
      end
      cpu_mask_i = 0;
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule